// File: doc/BRIEF.md
# Code Store Lock Controller

This block guards an on-chip code store with three lock bits. It keeps the bits and turns them into a protection level. The level decides three things: whether a table read made from external code may see the internal store, whether program verify is allowed, and whether external execution is allowed. The bits only ever move toward "programmed". The one way to return them to the unprogrammed state is a full chip-erase sequence. That sequence lasts a fixed number of cycles, and the bits clear when it ends.

The block also owns the external-access pin. A hardware reset captures the pin level. Once the first lock bit is programmed, the core steers its program fetches by that captured level instead of the live pin. Until the first hardware reset after power-up, the captured level has no meaning, and a validity flag shows this.

Lock-bit requests arrive on a valid/ready channel:
- A request is taken on a clock edge where both `lock_wr_valid` and `lock_wr_ready` are high.
- `lock_wr_ready` drops while an erase is running, and in any cycle where `erase_req` is high.
- A requester that finds the channel stalled keeps valid and its mask steady until the request is accepted.

`erase_req`, `hw_rst`, `ea_pin` and `fetch_ext` are plain control pins.

Top module: `code_lock_ctrl`

## Requirements
- R1: While `por_n` is low, and after it is released, the lock bits read 000. The level is 0, all three permissions are 1, `erase_busy` is 0 and `ea_held_valid` is 0.
- R2: An accepted request ORs `lock_wr_mask` into `lock_bits` on that edge. Bit 0 is the first lock bit, bit 1 the second and bit 2 the third, and 1 means programmed. A 0 in the mask leaves its bit as it is, so a request to unprogram is ignored.
- R3: `prot_level` is 0 when no bit is programmed. Otherwise it is 1 plus the index of the highest programmed bit. Any value with bit 2 set gives level 3.
- R4: `tbl_rd_ok` is 0 exactly when the level is at least 1 and `fetch_ext` is 1.
- R5: `verify_ok` is 0 exactly when the level is at least 2.
- R6: `ext_exec_ok` is 0 exactly when the level is 3.
- R7: On each edge where `hw_rst` is 1, `ea_held` captures `ea_pin` and `ea_held_valid` becomes 1. On other edges both hold their values. `hw_rst` never changes the lock bits.
- R8: `ea_use` follows the live `ea_pin` while bit 0 is clear and follows `ea_held` while bit 0 is set. `fetch_force_ext` is the inverse of `ea_use`.
- R9: When `erase_req` is seen on an edge with no erase running, `erase_busy` rises. It stays high for ERASE_CYCLES edges. On the edge where it falls, the lock bits become 000, and no other event clears them.
- R10: `lock_wr_ready` is 0 while `erase_busy` or `erase_req` is 1. A request in the same cycle as an erase request is therefore not taken.
- R11: An `erase_req` while an erase is already running is ignored and does not lengthen the erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| hw_rst | input | 1 | Hardware reset; captures the external-access pin |
| ea_pin | input | 1 | Live external-access pin level |
| fetch_ext | input | 1 | Current fetch comes from external memory |
| lock_wr_valid | input | 1 | Lock-bit program request valid |
| lock_wr_ready | output | 1 | Lock-bit program request can be taken |
| lock_wr_mask | input | 3 | Bits to program (1 = program) |
| erase_req | input | 1 | Chip-erase request |
| erase_busy | output | 1 | Erase sequence running |
| lock_bits | output | 3 | Current lock-bit state |
| prot_level | output | 2 | Protection level 0..3 |
| tbl_rd_ok | output | 1 | Table read of internal store permitted |
| verify_ok | output | 1 | Program verify permitted |
| ext_exec_ok | output | 1 | External execution permitted |
| ea_held | output | 1 | External-access level captured at reset |
| ea_held_valid | output | 1 | A hardware reset has captured `ea_held` |
| ea_use | output | 1 | External-access level in force |
| fetch_force_ext | output | 1 | Core must take all fetches from external memory |

## Verification
Two events can land on the same edge: a lock-bit program request and the start or end of an erase. The bench raises `erase_req` together with a valid request that would program all three bits. The scoreboard then expects the request to be refused: ready stays low, the bits do not change, and the erase clears them on schedule. The bench also repeats `erase_req` during the erase and checks that the clearing edge does not move. Hardware reset pulses are placed while the lock bits are set, to show that reset changes only the captured pin level.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;
  localparam int LOCK_W = 3;

  typedef enum logic [1:0] {
    LVL_OPEN   = 2'd0,
    LVL_NOTBL  = 2'd1,
    LVL_NOVRFY = 2'd2,
    LVL_NOEXT  = 2'd3
  } prot_lvl_e;

  // Highest programmed bit wins.
  function automatic prot_lvl_e lvl_of(input logic [LOCK_W-1:0] b);
    prot_lvl_e l;
    l = LVL_OPEN;
    for (int i = 0; i < LOCK_W; i++)
      if (b[i]) l = prot_lvl_e'(i + 1);
    return l;
  endfunction
endpackage

// File: rtl/lock_store.sv
module lock_store
  import code_lock_pkg::*;
#(
  parameter int ERASE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [LOCK_W-1:0] wr_mask,
  input  logic              erase_req,
  output logic              busy,
  output logic [LOCK_W-1:0] bits
);
  localparam int CW = (ERASE_CYCLES > 2) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(ERASE_CYCLES - 1);

  logic [CW-1:0] cnt;

  assign wr_ready = !busy && !erase_req;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      bits <= '0;
    end else if (busy) begin
      if (cnt == '0) begin
        busy <= 1'b0;
        bits <= '0;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end else if (erase_req) begin
      busy <= 1'b1;
      cnt  <= LAST;
    end else if (wr_valid) begin
      bits <= bits | wr_mask;
    end
  end
endmodule

// File: rtl/ea_hold.sv
module ea_hold (
  input  logic clk,
  input  logic por_n,
  input  logic hw_rst,
  input  logic ea_pin,
  input  logic use_held,
  output logic held,
  output logic held_valid,
  output logic ea_use
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      held       <= 1'b0;
      held_valid <= 1'b0;
    end else if (hw_rst) begin
      held       <= ea_pin;
      held_valid <= 1'b1;
    end
  end

  assign ea_use = use_held ? held : ea_pin;
endmodule

// File: rtl/perm_decode.sv
module perm_decode
  import code_lock_pkg::*;
(
  input  logic [LOCK_W-1:0] bits,
  input  logic              fetch_ext,
  output prot_lvl_e         level,
  output logic              tbl_ok,
  output logic              vrfy_ok,
  output logic              exec_ok
);
  logic [LOCK_W-1:0] at_least;

  assign level = lvl_of(bits);

  generate
    for (genvar g = 0; g < LOCK_W; g++) begin : g_thr
      assign at_least[g] = (int'(level) >= g + 1);
    end
  endgenerate

  assign tbl_ok  = !(at_least[0] && fetch_ext);
  assign vrfy_ok = !at_least[1];
  assign exec_ok = !at_least[2];
endmodule

// File: rtl/code_lock_ctrl.sv
module code_lock_ctrl
  import code_lock_pkg::*;
#(
  parameter int ERASE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       hw_rst,
  input  logic       ea_pin,
  input  logic       fetch_ext,
  input  logic       lock_wr_valid,
  output logic       lock_wr_ready,
  input  logic [2:0] lock_wr_mask,
  input  logic       erase_req,
  output logic       erase_busy,
  output logic [2:0] lock_bits,
  output logic [1:0] prot_level,
  output logic       tbl_rd_ok,
  output logic       verify_ok,
  output logic       ext_exec_ok,
  output logic       ea_held,
  output logic       ea_held_valid,
  output logic       ea_use,
  output logic       fetch_force_ext
);
  prot_lvl_e lvl;

  lock_store #(.ERASE_CYCLES(ERASE_CYCLES)) u_store (
    .clk       (clk),
    .por_n     (por_n),
    .wr_valid  (lock_wr_valid),
    .wr_ready  (lock_wr_ready),
    .wr_mask   (lock_wr_mask),
    .erase_req (erase_req),
    .busy      (erase_busy),
    .bits      (lock_bits)
  );

  ea_hold u_ea (
    .clk        (clk),
    .por_n      (por_n),
    .hw_rst     (hw_rst),
    .ea_pin     (ea_pin),
    .use_held   (lock_bits[0]),
    .held       (ea_held),
    .held_valid (ea_held_valid),
    .ea_use     (ea_use)
  );

  perm_decode u_dec (
    .bits      (lock_bits),
    .fetch_ext (fetch_ext),
    .level     (lvl),
    .tbl_ok    (tbl_rd_ok),
    .vrfy_ok   (verify_ok),
    .exec_ok   (ext_exec_ok)
  );

  assign prot_level      = 2'(lvl);
  assign fetch_force_ext = !ea_use;
endmodule

// File: rtl/code_lock_chk.sv
module code_lock_chk (
  input logic       clk,
  input logic       por_n,
  input logic       hw_rst,
  input logic       ea_pin,
  input logic       fetch_ext,
  input logic       lock_wr_ready,
  input logic       erase_req,
  input logic       erase_busy,
  input logic [2:0] lock_bits,
  input logic [1:0] prot_level,
  input logic       tbl_rd_ok,
  input logic       verify_ok,
  input logic       ext_exec_ok,
  input logic       ea_held,
  input logic       ea_held_valid
);
  p_bits_grow_r2: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> ($fell(erase_busy) || ((lock_bits & $past(lock_bits)) == $past(lock_bits))));

  p_erase_clears_r9: assert property (@(posedge clk) disable iff (!por_n)
    $fell(erase_busy) |-> (lock_bits == 3'b000));

  p_no_accept_r10: assert property (@(posedge clk) disable iff (!por_n)
    (erase_busy || erase_req) |-> !lock_wr_ready);

  p_tbl_block_r4: assert property (@(posedge clk) disable iff (!por_n)
    (prot_level != 2'd0 && fetch_ext) |-> !tbl_rd_ok);

  p_vrfy_block_r5: assert property (@(posedge clk) disable iff (!por_n)
    (prot_level >= 2'd2) |-> !verify_ok);

  p_exec_block_r6: assert property (@(posedge clk) disable iff (!por_n)
    lock_bits[2] |-> (!ext_exec_ok && prot_level == 2'd3));

  p_capture_r7: assert property (@(posedge clk) disable iff (!por_n)
    hw_rst |=> (ea_held_valid && ea_held == $past(ea_pin)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!por_n)
    !hw_rst |=> ($stable(ea_held) && $stable(ea_held_valid)));
endmodule

bind code_lock_ctrl code_lock_chk u_chk (
  .clk           (clk),
  .por_n         (por_n),
  .hw_rst        (hw_rst),
  .ea_pin        (ea_pin),
  .fetch_ext     (fetch_ext),
  .lock_wr_ready (lock_wr_ready),
  .erase_req     (erase_req),
  .erase_busy    (erase_busy),
  .lock_bits     (lock_bits),
  .prot_level    (prot_level),
  .tbl_rd_ok     (tbl_rd_ok),
  .verify_ok     (verify_ok),
  .ext_exec_ok   (ext_exec_ok),
  .ea_held       (ea_held),
  .ea_held_valid (ea_held_valid)
);

// File: tb/code_lock_ctrl_tb.sv
module code_lock_ctrl_tb;
  localparam int NER = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic hw_rst = 1'b0, ea_pin = 1'b0, fetch_ext = 1'b0;
  logic lock_wr_valid = 1'b0, erase_req = 1'b0;
  logic [2:0] lock_wr_mask = 3'b000;
  logic lock_wr_ready, erase_busy, tbl_rd_ok, verify_ok, ext_exec_ok;
  logic ea_held, ea_held_valid, ea_use, fetch_force_ext;
  logic [2:0] lock_bits;
  logic [1:0] prot_level;

  always #5 clk = ~clk;

  code_lock_ctrl #(.ERASE_CYCLES(NER)) u_dut (
    .clk(clk), .por_n(por_n), .hw_rst(hw_rst), .ea_pin(ea_pin),
    .fetch_ext(fetch_ext), .lock_wr_valid(lock_wr_valid),
    .lock_wr_ready(lock_wr_ready), .lock_wr_mask(lock_wr_mask),
    .erase_req(erase_req), .erase_busy(erase_busy), .lock_bits(lock_bits),
    .prot_level(prot_level), .tbl_rd_ok(tbl_rd_ok), .verify_ok(verify_ok),
    .ext_exec_ok(ext_exec_ok), .ea_held(ea_held),
    .ea_held_valid(ea_held_valid), .ea_use(ea_use),
    .fetch_force_ext(fetch_force_ext)
  );

  typedef struct packed {
    logic [2:0] bits;
    logic [1:0] lvl;
    logic tbl, vrf, exe, busy, rdy, held, hvld, use_, force_;
  } exp_t;

  exp_t q[$];
  event ev_chk;
  int n_chk = 0, n_bad = 0;

  // bench model state
  logic [2:0] m_bits = 3'b000;
  logic m_busy = 1'b0;
  int   m_cnt = 0;
  logic m_held = 1'b0, m_hvld = 1'b0;

  function automatic exp_t predict(input logic fx, input logic ea, input logic er);
    exp_t e;
    e.bits = m_bits;
    e.lvl  = m_bits[2] ? 2'd3 : m_bits[1] ? 2'd2 : m_bits[0] ? 2'd1 : 2'd0;
    e.tbl  = !(e.lvl != 2'd0 && fx);
    e.vrf  = (e.lvl < 2'd2);
    e.exe  = (e.lvl != 2'd3);
    e.busy = m_busy;
    e.rdy  = !m_busy && !er;
    e.held = m_held;
    e.hvld = m_hvld;
    e.use_ = m_bits[0] ? m_held : ea;
    e.force_ = !e.use_;
    return e;
  endfunction

  task automatic step(input logic wv, input logic [2:0] mk, input logic er,
                      input logic rs, input logic ea, input logic fx);
    logic rdy_pre;
    @(negedge clk);
    lock_wr_valid = wv; lock_wr_mask = mk; erase_req = er;
    hw_rst = rs; ea_pin = ea; fetch_ext = fx;
    rdy_pre = !m_busy && !er;
    // model the edge
    if (m_busy) begin
      if (m_cnt == 0) begin m_busy = 1'b0; m_bits = 3'b000; end
      else m_cnt--;
    end else if (er) begin
      m_busy = 1'b1; m_cnt = NER - 1;
    end else if (wv && rdy_pre) begin
      m_bits = m_bits | mk;
    end
    if (rs) begin m_held = ea; m_hvld = 1'b1; end
    @(posedge clk);
    #2;
    q.push_back(predict(fx, ea, er));
    -> ev_chk;
  endtask

  task automatic cmp1(input string tag, input logic [2:0] act, input logic [2:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(ev_chk);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        cmp1("R2 lock_bits", lock_bits, e.bits);
        cmp1("R3 prot_level", {1'b0, prot_level}, {1'b0, e.lvl});
        cmp1("R4 tbl_rd_ok", {2'b0, tbl_rd_ok}, {2'b0, e.tbl});
        cmp1("R5 verify_ok", {2'b0, verify_ok}, {2'b0, e.vrf});
        cmp1("R6 ext_exec_ok", {2'b0, ext_exec_ok}, {2'b0, e.exe});
        cmp1("R9 erase_busy", {2'b0, erase_busy}, {2'b0, e.busy});
        cmp1("R10 lock_wr_ready", {2'b0, lock_wr_ready}, {2'b0, e.rdy});
        cmp1("R7 ea_held_valid", {2'b0, ea_held_valid}, {2'b0, e.hvld});
        if (e.hvld) cmp1("R7 ea_held", {2'b0, ea_held}, {2'b0, e.held});
        if (e.hvld || !e.bits[0]) begin
          cmp1("R8 ea_use", {2'b0, ea_use}, {2'b0, e.use_});
          cmp1("R8 fetch_force_ext", {2'b0, fetch_force_ext}, {2'b0, e.force_});
        end
      end
    end
  end

  initial begin : wdog
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state while por_n low and right after release
    repeat (2) @(posedge clk);
    #2;
    n_chk++;
    if (lock_bits !== 3'b000 || prot_level !== 2'd0 || !tbl_rd_ok || !verify_ok ||
        !ext_exec_ok || erase_busy || ea_held_valid) begin
      n_bad++;
      $display("FAIL R1 reset state actual=%b%b%b%b%b%b%b expected=000 0 1 1 1 0 0",
               lock_bits, prot_level, tbl_rd_ok, verify_ok, ext_exec_ok,
               erase_busy, ea_held_valid);
    end
    @(negedge clk); por_n = 1'b1;
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1);   // R1 after release, level 0
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);   // R8 live pin followed
    step(1'b0, 3'b000, 1'b0, 1'b1, 1'b1, 1'b0);   // R7 capture 1
    step(1'b1, 3'b001, 1'b0, 1'b0, 1'b0, 1'b1);   // R2 program first bit
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1);   // R4 blocked, R8 held used
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0);   // R4 ok on internal fetch
    step(1'b1, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0);   // R2 zero mask ignored
    step(1'b1, 3'b100, 1'b0, 1'b0, 1'b0, 1'b1);   // R3 third bit gives level 3
    step(1'b0, 3'b000, 1'b0, 1'b1, 1'b0, 1'b0);   // R7 reset keeps bits, captures 0
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0);   // R8 held 0 wins over pin 1
    // R10: erase and write in the same cycle, erase wins
    step(1'b1, 3'b111, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 3'b111, 1'b0, 1'b0, 1'b0, 1'b0);   // R10 stalled while busy
    step(1'b0, 3'b000, 1'b1, 1'b0, 1'b0, 1'b0);   // R11 extra erase_req ignored
    for (int i = 0; i < NER + 1; i++)
      step(1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b1); // R9 bits clear at end
    step(1'b1, 3'b010, 1'b0, 1'b0, 1'b1, 1'b1);   // R3 second bit alone -> level 2
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b1, 1'b0);   // R5 verify blocked, R8 live pin
    step(1'b1, 3'b001, 1'b0, 1'b0, 1'b0, 1'b1);   // R6 exec still allowed at level 2
    step(1'b0, 3'b000, 1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule